// File: doc/BRIEF.md
# Codec Serial Frame-Sync Slave Port

This block connects a chip to an external audio or telecom codec that owns the serial timing. The codec drives the bit clock and the frame-sync line. The port follows them, shifts one serial output line and captures one serial input line. The block runs on a fast system clock. The bit clock and frame sync are oversampled there, so every parallel strobe is a single system-clock pulse.

Three framing rules can be selected:

- **Time-division multichannel:** a frame starts when frame sync is seen high.
- **Stereo word-select:** a frame starts when frame sync changes level in either direction.
- **AC-Link style:** a frame opens with a fixed 16-bit tag slot, followed by the data slots.

In all three rules, frame length comes from two configuration inputs, the word size and the number of slots. The frame starts on the bit clock after the sync is sampled. Once a frame has started, it runs to its end. A sync that arrives before the end is ignored, except one that arrives during the very last bit. That sync chains the next frame directly behind the current one.

Transmit words are pulled one slot ahead through a load strobe and a slot index. Received words come out right-aligned, with a valid strobe and a slot index.

Top module: `csi_serial_slave`

## Requirements
- R1: With `cfg_mode`=0 (multichannel), sampling `fsync_in` high on a rising bit-clock edge while idle starts a frame. The MSB of slot 0 is transferred in the next bit-clock period. The frame holds `cfg_slots`+1 words of `cfg_wlen`+1 bits each.
- R2: With `cfg_mode`=1 (word-select), a change of the sampled `fsync_in` level, either rising or falling, starts a frame in the next bit-clock period. The frame size is the same as in R1. The remembered previous level is 0 after reset.
- R3: With `cfg_mode`=2 (AC-Link style), sampling `fsync_in` high starts a frame in the next bit-clock period. Slot 0 is a 16-bit tag, whatever `cfg_wlen` holds. Slots 1 to `cfg_slots` carry `cfg_wlen`+1 bits each.
- R4: Words travel MSB first on both lines. `sdo_out` changes only after a falling bit-clock edge. `sdi_in` is captured on rising bit-clock edges.
- R5: When the last bit of a slot has been captured, `rx_valid` pulses for exactly one system cycle, with `rx_slot` giving the slot index. `rx_word` then holds the slot's bits right-aligned, with all bits above the slot length at zero.
- R6: `tx_load` pulses for one system cycle when a frame starts (with `tx_slot`=0) and at each later word boundary (with `tx_slot` set to the next slot index). `tx_word` is taken on the clock edge where `tx_load` is high. There is exactly one load per slot.
- R7: Any sync event sampled during a frame, other than in its last bit, is ignored. The frame continues unchanged.
- R8: A sync event sampled together with the last bit of a frame starts the next frame right away, with no idle bit between the two frames.
- R9: After reset, and until the first accepted sync, `sdo_out` is low and no strobes are produced. After a frame ends with no new sync, `sdo_out` returns low.
- R10: The mode encoding 3 behaves exactly like multichannel mode (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing rule: 0 multichannel, 1 word-select, 2 AC-Link style, 3 same as 0 |
| cfg_wlen | input | 4 | Data word length minus one |
| cfg_slots | input | 3 | Slots per frame minus one |
| bclk_in | input | 1 | Bit clock from the codec |
| fsync_in | input | 1 | Frame sync from the codec |
| sdi_in | input | 1 | Serial data from the codec |
| sdo_out | output | 1 | Serial data to the codec |
| tx_word | input | 16 | Transmit word for the slot named by `tx_slot` |
| tx_slot | output | 3 | Slot whose transmit word is being loaded |
| tx_load | output | 1 | One-cycle strobe: `tx_word` is taken on this cycle |
| rx_word | output | 16 | Last received word, right-aligned |
| rx_slot | output | 3 | Slot index of `rx_word` |
| rx_valid | output | 1 | One-cycle strobe for a newly received word |

## Verification
The hardest case to reach is a sync that lands exactly on the last bit of a frame, because it must be accepted while a sync one bit earlier must be ignored. The bench models the codec bit by bit and places a sync event at any chosen bit position of the frame. This lets it insert a mid-frame pulse or level change in every swept frame. It also asserts sync on the final bit to chain a second frame behind the first. In word-select mode, the same model toggles the level so that both directions of edge are exercised.

// File: rtl/csi_pkg.sv
package csi_pkg;

  typedef enum logic [1:0] {
    MODE_TDM = 2'd0,
    MODE_I2S = 2'd1,
    MODE_ACL = 2'd2,
    MODE_ALT = 2'd3
  } csi_mode_e;

  localparam int TAG_BITS = 16;

  // Number of bits in a slot for the given framing rule.
  function automatic int slot_bits(logic [1:0] mode, int slot, int wlen_m1);
    if (mode == MODE_ACL && slot == 0) return TAG_BITS;
    return wlen_m1 + 1;
  endfunction

  // Whether the sampled frame-sync level counts as a sync event.
  function automatic logic sync_hit(logic [1:0] mode, logic fs_now, logic fs_prev);
    if (mode == MODE_I2S) return fs_now ^ fs_prev;
    return fs_now;
  endfunction

  // Mask with the low 'bits' bits set.
  function automatic logic [31:0] low_mask(int bits);
    if (bits >= 32) return '1;
    return (32'd1 << bits) - 32'd1;
  endfunction

endpackage

// File: rtl/csi_pin_sync.sv
module csi_pin_sync #(
  parameter int DATA_PINS = 2,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_raw,
  input  logic [DATA_PINS-1:0] data_raw,
  output logic [DATA_PINS-1:0] data_s,
  output logic                 bclk_rise,
  output logic                 bclk_fall
);
  localparam int PINS = DATA_PINS + 1;

  logic [STAGES-1:0][PINS-1:0] stg;
  logic                        bclk_prev;
  logic                        bclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg       <= '0;
      bclk_prev <= 1'b0;
    end else begin
      stg[0] <= {data_raw, bclk_raw};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      bclk_prev <= stg[STAGES-1][0];
    end
  end

  assign bclk_s    = stg[STAGES-1][0];
  assign data_s    = stg[STAGES-1][PINS-1:1];
  assign bclk_rise = bclk_s & ~bclk_prev;
  assign bclk_fall = ~bclk_s & bclk_prev;
endmodule

// File: rtl/csi_frame_ctl.sv
module csi_frame_ctl
  import csi_pkg::*;
#(
  parameter  int W_MAX    = 16,
  parameter  int SLOT_MAX = 8,
  localparam int LW       = $clog2(W_MAX + 1),
  localparam int WLW      = $clog2(W_MAX),
  localparam int SW       = $clog2(SLOT_MAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [WLW-1:0] wlen,
  input  logic [SW-1:0]  slots,
  input  logic           bclk_rise,
  input  logic           fs_s,
  output logic           busy,
  output logic           accept,
  output logic           word_end,
  output logic           frame_last,
  output logic           ever_sync,
  output logic [LW-1:0]  bit_q,
  output logic [LW-1:0]  cur_len,
  output logic [SW-1:0]  slot_q
);
  logic fs_prev;
  logic hit;

  assign cur_len    = LW'(slot_bits(mode, int'(slot_q), int'(wlen)));
  assign hit        = sync_hit(mode, fs_s, fs_prev);
  assign word_end   = busy & bclk_rise & (bit_q == cur_len - LW'(1));
  assign frame_last = word_end & (slot_q == slots);
  // A sync is taken while idle, or on the very last bit of a frame.
  assign accept     = bclk_rise & hit & (~busy | frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev   <= 1'b0;
      busy      <= 1'b0;
      ever_sync <= 1'b0;
      bit_q     <= '0;
      slot_q    <= '0;
    end else begin
      if (bclk_rise) fs_prev <= fs_s;
      if (accept) begin
        busy      <= 1'b1;
        ever_sync <= 1'b1;
        bit_q     <= '0;
        slot_q    <= '0;
      end else if (frame_last) begin
        busy   <= 1'b0;
        bit_q  <= '0;
        slot_q <= '0;
      end else if (word_end) begin
        bit_q  <= '0;
        slot_q <= slot_q + SW'(1);
      end else if (busy && bclk_rise) begin
        bit_q <= bit_q + LW'(1);
      end
    end
  end
endmodule

// File: rtl/csi_shifter.sv
module csi_shifter
  import csi_pkg::*;
#(
  parameter  int W_MAX    = 16,
  parameter  int SLOT_MAX = 8,
  localparam int LW       = $clog2(W_MAX + 1),
  localparam int WLW      = $clog2(W_MAX),
  localparam int SW       = $clog2(SLOT_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             sdi_s,
  input  logic             busy,
  input  logic             accept,
  input  logic             word_end,
  input  logic             frame_last,
  input  logic [LW-1:0]    bit_q,
  input  logic [LW-1:0]    cur_len,
  input  logic [SW-1:0]    slot_q,
  input  logic [W_MAX-1:0] tx_word,
  output logic             sdo_out,
  output logic             tx_load,
  output logic [SW-1:0]    tx_slot,
  output logic [W_MAX-1:0] rx_word,
  output logic [SW-1:0]    rx_slot,
  output logic             rx_valid
);
  logic [W_MAX-1:0] tx_sh;
  logic [W_MAX-1:0] rx_sh;
  logic [W_MAX-1:0] rx_next;
  logic [W_MAX-1:0] len_mask;
  logic [WLW-1:0]   tx_idx;

  assign tx_load  = accept | (word_end & ~frame_last);
  assign tx_slot  = accept ? '0 : slot_q + SW'(1);
  assign tx_idx   = WLW'(cur_len - LW'(1) - bit_q);
  assign rx_next  = {rx_sh[W_MAX-2:0], sdi_s};
  assign len_mask = W_MAX'(low_mask(int'(cur_len)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      sdo_out  <= 1'b0;
      rx_word  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_load) tx_sh <= tx_word;
      if (bclk_fall) sdo_out <= busy & tx_sh[tx_idx];
      if (bclk_rise && busy) rx_sh <= rx_next;
      if (word_end) begin
        rx_valid <= 1'b1;
        rx_word  <= rx_next & len_mask;
        rx_slot  <= slot_q;
      end
    end
  end
endmodule

// File: rtl/csi_serial_slave.sv
module csi_serial_slave
  import csi_pkg::*;
#(
  parameter  int W_MAX    = 16,
  parameter  int SLOT_MAX = 8,
  localparam int LW       = $clog2(W_MAX + 1),
  localparam int WLW      = $clog2(W_MAX),
  localparam int SW       = $clog2(SLOT_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [WLW-1:0]   cfg_wlen,
  input  logic [SW-1:0]    cfg_slots,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic             sdi_in,
  output logic             sdo_out,
  input  logic [W_MAX-1:0] tx_word,
  output logic [SW-1:0]    tx_slot,
  output logic             tx_load,
  output logic [W_MAX-1:0] rx_word,
  output logic [SW-1:0]    rx_slot,
  output logic             rx_valid
);
  logic [1:0]    pins_s;
  logic          bclk_rise, bclk_fall;
  logic          busy, accept, word_end, frame_last, ever_sync;
  logic [LW-1:0] bit_q, cur_len;
  logic [SW-1:0] slot_q;

  csi_pin_sync #(.DATA_PINS(2), .STAGES(2)) u_pins (
    .clk(clk), .rst_n(rst_n), .bclk_raw(bclk_in),
    .data_raw({sdi_in, fsync_in}), .data_s(pins_s),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  csi_frame_ctl #(.W_MAX(W_MAX), .SLOT_MAX(SLOT_MAX)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .wlen(cfg_wlen), .slots(cfg_slots),
    .bclk_rise(bclk_rise), .fs_s(pins_s[0]), .busy(busy), .accept(accept),
    .word_end(word_end), .frame_last(frame_last), .ever_sync(ever_sync),
    .bit_q(bit_q), .cur_len(cur_len), .slot_q(slot_q)
  );

  csi_shifter #(.W_MAX(W_MAX), .SLOT_MAX(SLOT_MAX)) u_shf (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .sdi_s(pins_s[1]), .busy(busy), .accept(accept), .word_end(word_end),
    .frame_last(frame_last), .bit_q(bit_q), .cur_len(cur_len), .slot_q(slot_q),
    .tx_word(tx_word), .sdo_out(sdo_out), .tx_load(tx_load), .tx_slot(tx_slot),
    .rx_word(rx_word), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/csi_checker.sv
module csi_checker
  import csi_pkg::*;
#(
  parameter  int W_MAX    = 16,
  parameter  int SLOT_MAX = 8,
  localparam int LW       = $clog2(W_MAX + 1),
  localparam int WLW      = $clog2(W_MAX),
  localparam int SW       = $clog2(SLOT_MAX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [WLW-1:0]   cfg_wlen,
  input logic [SW-1:0]    cfg_slots,
  input logic             sdo_out,
  input logic             tx_load,
  input logic [SW-1:0]    tx_slot,
  input logic             rx_valid,
  input logic [SW-1:0]    rx_slot,
  input logic [W_MAX-1:0] rx_word,
  input logic             busy,
  input logic             frame_last,
  input logic             bclk_rise,
  input logic             ever_sync,
  input logic [LW-1:0]    bit_q,
  input logic [SW-1:0]    slot_q
);
  AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);  // R5
  AST_RX_WORD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !(cfg_mode == MODE_ACL && rx_slot == '0) |-> ((rx_word >> cfg_wlen) >> 1) == '0);  // R5
  AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_slot <= cfg_slots);  // R1
  AST_RX_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));  // R9
  AST_TX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_slot <= cfg_slots);  // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bclk_rise && !frame_last |=> (bit_q != '0 || slot_q != '0));  // R7
  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !ever_sync |-> !sdo_out && !rx_valid);  // R9
endmodule

bind csi_serial_slave csi_checker #(.W_MAX(W_MAX), .SLOT_MAX(SLOT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots),
  .sdo_out(sdo_out), .tx_load(tx_load), .tx_slot(tx_slot), .rx_valid(rx_valid),
  .rx_slot(rx_slot), .rx_word(rx_word), .busy(busy), .frame_last(frame_last),
  .bclk_rise(bclk_rise), .ever_sync(ever_sync), .bit_q(bit_q), .slot_q(slot_q)
);

// File: tb/test_csi_serial_slave.sv
module test_csi_serial_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_wlen;
  logic [2:0]  cfg_slots;
  logic        bclk_in, fsync_in, sdi_in, sdo_out;
  logic [15:0] tx_word, rx_word;
  logic [2:0]  tx_slot, rx_slot;
  logic        tx_load, rx_valid;

  int total = 0, bad = 0;
  int ev_n = 0, tl_n = 0, exp_n = 0, exp_tl = 0;
  logic [2:0]  ev_slot [64];
  logic [2:0]  exp_slot[64];
  logic [15:0] ev_word [64];
  logic [15:0] exp_word[64];
  logic fs_lvl = 1'b0;

  function automatic logic [15:0] tx_pat(logic [2:0] s);
    return 16'hC6A1 + 16'(s) * 16'h3A95;
  endfunction
  function automatic logic [15:0] rx_pat(logic [2:0] s);
    return 16'h9B35 ^ (16'(s) * 16'h2D71);
  endfunction
  function automatic logic [15:0] lmask(int n);
    if (n >= 16) return 16'hFFFF;
    return 16'((32'd1 << n) - 32'd1);
  endfunction

  assign tx_word = tx_pat(tx_slot);

  csi_serial_slave i_csi_serial_slave (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .sdi_in(sdi_in), .sdo_out(sdo_out),
    .tx_word(tx_word), .tx_slot(tx_slot), .tx_load(tx_load),
    .rx_word(rx_word), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      if (ev_n < 64) begin ev_slot[ev_n] = rx_slot; ev_word[ev_n] = rx_word; end
      ev_n++;
    end
    if (tx_load) tl_n++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One codec bit period: drive on the falling edge, sample sdo just before the rise.
  task automatic bit_cycle(input logic fs, input logic sd, output logic so);
    @(negedge clk);
    bclk_in = 1'b0; fsync_in = fs; sdi_in = sd;
    repeat (4) @(negedge clk);
    so = sdo_out;
    bclk_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input int mode, input int wl, input int ns, input bit do_sync,
                           input int mid_bit, input bit chain, input string req);
    logic so;
    logic [15:0] got;
    int bpos = 0;
    if (do_sync) begin
      if (mode == 1) begin fs_lvl = ~fs_lvl; bit_cycle(fs_lvl, 1'b0, so); end
      else begin fs_lvl = 1'b0; bit_cycle(1'b1, 1'b0, so); end
    end
    for (int s = 0; s <= ns; s++) begin
      int len = (mode == 2 && s == 0) ? 16 : wl + 1;
      logic [15:0] rp = rx_pat(3'(s));
      got = '0;
      for (int b = 0; b < len; b++) begin
        bit ev = (bpos == mid_bit) || ((s == ns) && (b == len - 1) && chain);
        logic fsv;
        if (mode == 1) begin if (ev) fs_lvl = ~fs_lvl; fsv = fs_lvl; end
        else fsv = ev;
        bit_cycle(fsv, rp[len-1-b], so);
        got = {got[14:0], so};
        bpos++;
      end
      chk(req, $sformatf("R4 tx bits MSB first, slot %0d", s), 32'(got), 32'(tx_pat(3'(s)) & lmask(len)));
      exp_slot[exp_n] = 3'(s);
      exp_word[exp_n] = rp & lmask(len);
      exp_n++;
      exp_tl++;
    end
  endtask

  task automatic idle_and_compare(input int mode, input string req, input bit locked);
    logic so;
    int nz = 0;
    for (int i = 0; i < 4; i++) begin
      bit_cycle(mode == 1 ? fs_lvl : 1'b0, 1'b1, so);
      if (so !== 1'b0) nz++;
    end
    chk("R9", "sdo high after frame end", 32'(nz), 0);
    chk(req, "rx strobe count", 32'(ev_n), 32'(exp_n));
    if (locked) chk("R7", "strobes with mid-frame sync", 32'(ev_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      chk(req, "rx slot index", 32'(ev_slot[i]), 32'(exp_slot[i]));
      chk("R5", "rx word", 32'(ev_word[i]), 32'(exp_word[i]));
    end
    chk("R6", "tx load count", 32'(tl_n), 32'(exp_tl));
    ev_n = 0; exp_n = 0; tl_n = 0; exp_tl = 0;
  endtask

  function automatic string mode_req(int m);
    if (m == 1) return "R2";
    if (m == 2) return "R3";
    if (m == 3) return "R10";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic so;
    int nz;
    int wls[3] = '{3, 7, 15};
    int nss[3] = '{0, 1, 3};
    cfg_mode = 2'd0; cfg_wlen = 4'd7; cfg_slots = 3'd1;
    bclk_in = 1'b0; fsync_in = 1'b0; sdi_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset sdo", 32'(sdo_out), 0);
    chk("R9", "reset rx_valid", 32'(rx_valid), 0);
    chk("R9", "reset tx_load", 32'(tx_load), 0);

    // No sync yet: serial input toggles, output must stay quiet.
    nz = 0;
    for (int i = 0; i < 6; i++) begin
      bit_cycle(1'b0, 1'b1, so);
      if (so !== 1'b0) nz++;
    end
    chk("R9", "sdo before first sync", 32'(nz), 0);
    chk("R9", "strobes before first sync", 32'(ev_n + tl_n), 0);
    ev_n = 0; tl_n = 0;

    // Sweep: every framing rule, word length and slot count, with a mid-frame sync.
    for (int m = 0; m < 3; m++)
      for (int wi = 0; wi < 3; wi++)
        for (int ni = 0; ni < 3; ni++) begin
          cfg_mode = 2'(m); cfg_wlen = 4'(wls[wi]); cfg_slots = 3'(nss[ni]);
          run_frame(m, wls[wi], nss[ni], 1'b1, 1, 1'b0, mode_req(m));
          idle_and_compare(m, mode_req(m), 1'b1);
        end

    // Back-to-back frames: sync on the last bit of the first.
    for (int m = 0; m < 3; m++) begin
      cfg_mode = 2'(m); cfg_wlen = 4'd5; cfg_slots = 3'd2;
      run_frame(m, 5, 2, 1'b1, -1, 1'b1, "R8");
      run_frame(m, 5, 2, 1'b0, -1, 1'b0, "R8");
      idle_and_compare(m, "R8", 1'b0);
    end

    // Reserved encoding acts as multichannel.
    cfg_mode = 2'd3; cfg_wlen = 4'd9; cfg_slots = 3'd1;
    run_frame(3, 9, 1, 1'b1, 2, 1'b0, mode_req(3));
    idle_and_compare(3, mode_req(3), 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule